// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers 64 level-sensitive interrupt sources and raises two requests toward a processor. One is a normal request, ranked by a per-source priority. The other is a fast request, for sources that software has marked urgent. Each source has three settings: an enable bit, a routing bit that chooses the normal or the fast path, and a 4-bit priority. A software force bit can assert a source as though its input line were high.

Software works through a single-cycle register port. A write lands on the next clock edge. A read returns the addressed word combinationally in the same cycle. The port carries a word index, which is the byte offset divided by four.

Two vector words do the source lookup for the handler:
- The normal vector word names the winning normal source in its upper half.
- The fast vector word names the lowest-numbered pending fast source in its upper half.
- In both words, 0xFFFF in the upper half means that nothing qualifies.

A 5-bit level register acts as a threshold for the normal path. Only sources whose priority is strictly above the level can win. The level resets to 0x1F, so the normal path starts silent.

Top module: `vic_core`

## Requirements
- R1: After reset, every enable, routing and force bit, every priority field and the control word at byte offset 0x00 read zero. The level register at 0x04 reads 0x1F. Both vector words read 0xFFFF0000. Both request outputs are low.
- R2: The control word at 0x00 is 32-bit read/write storage. The enable words are read/write: 0x14 holds sources 0 to 31 and 0x10 holds sources 32 to 63, with bit n of a word standing for source n (low word) or n+32 (high word).
- R3: Writing a value v below 64 to 0x08 sets the enable bit of source v, and writing it to 0x0C clears that bit. A value of 64 or more written to either offset leaves all 64 enable bits unchanged.
- R4: The routing words are read/write: 0x1C holds sources 0 to 31 and 0x18 holds sources 32 to 63. A routing bit of 1 places the source on the fast path and 0 places it on the normal path.
- R5: The force words are read/write: 0x54 holds sources 0 to 31 and 0x50 holds sources 32 to 63. The raw words read the input lines: 0x4C reads sources 0 to 31 and 0x48 reads sources 32 to 63. Writes to the raw words are ignored.
- R6: A source is normal-pending when (input OR force) AND enable AND NOT routing, and fast-pending when (input OR force) AND enable AND routing. Normal pending reads at 0x5C (low half) and 0x58 (high half). Fast pending reads at 0x64 (low half) and 0x60 (high half).
- R7: Each of the eight priority words holds eight 4-bit fields. Word k covers sources 8k to 8k+7, with source 8k in bits 3:0, and sits at byte offset 0x20 + 4*(7-k). Word 7 is therefore at 0x20 and word 0 at 0x3C.
- R8: The normal vector word at 0x40 carries, in bits 31:16, the number of the normal-pending source with the largest priority among those whose priority exceeds the level. Among equal priorities the higher source number wins. The field reads 0xFFFF when no source qualifies. Bits 15:0 read zero.
- R9: The level register at 0x04 keeps the low 5 bits of a write. Any level of 15 or above, the reset value 0x1F included, keeps every source off the normal path.
- R10: The fast vector word at 0x44 carries, in bits 31:16, the lowest fast-pending source number, or 0xFFFF when none is pending. Bits 15:0 read zero.
- R11: The normal request is a register that holds the OR of the qualified normal-pending sources. The fast request is a register that holds the OR of the fast-pending sources. Both follow a change in a register or an input one clock edge later.
- R12: The enable-by-number offsets 0x08 and 0x0C, and every word index from 26 to 31, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe; the write lands on the next rising edge |
| bus_widx_i | input | 5 | Word index, equal to the byte offset divided by four |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_widx_i, available in the same cycle |
| src_i | input | 64 | Level-sensitive interrupt inputs, bit n is source n |
| irq_norm_o | output | 1 | Registered normal interrupt request |
| irq_fast_o | output | 1 | Registered fast interrupt request |

## Verification
The main coincidence is an input level change that arrives in the same cycle as a software write to that source's enable, routing, force, priority or level setting. Both effects then fold into the same vector result and the same request flop. The bench provokes this by changing the whole input vector and issuing a random register write at the same drive point, cycle after cycle. A behavioural model judges each cycle. The model computes the request from the state before the edge and applies the write afterwards. Its expected vector and read data are compared with the design on every clock.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;

  localparam int NUM_SRC   = 64;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int DATA_W    = 32;
  localparam int HALF_W    = DATA_W;
  localparam int PRIO_W    = 4;
  localparam int MASK_W    = 5;
  localparam int ID_W      = 16;
  localparam int WIDX_W    = 5;
  localparam int PER_WORD  = DATA_W / PRIO_W;
  localparam int PRIO_REGS = NUM_SRC / PER_WORD;

  localparam logic [ID_W-1:0] NO_SRC_ID = '1;

  localparam logic [WIDX_W-1:0] WI_CTRL  = 5'd0;
  localparam logic [WIDX_W-1:0] WI_LEVEL = 5'd1;
  localparam logic [WIDX_W-1:0] WI_ENUM  = 5'd2;
  localparam logic [WIDX_W-1:0] WI_DNUM  = 5'd3;
  localparam logic [WIDX_W-1:0] WI_ENH   = 5'd4;
  localparam logic [WIDX_W-1:0] WI_ENL   = 5'd5;
  localparam logic [WIDX_W-1:0] WI_TYPH  = 5'd6;
  localparam logic [WIDX_W-1:0] WI_TYPL  = 5'd7;
  localparam int                WI_PRIO_BASE = 8;
  localparam logic [WIDX_W-1:0] WI_NVEC  = 5'd16;
  localparam logic [WIDX_W-1:0] WI_FVEC  = 5'd17;
  localparam logic [WIDX_W-1:0] WI_RAWH  = 5'd18;
  localparam logic [WIDX_W-1:0] WI_RAWL  = 5'd19;
  localparam logic [WIDX_W-1:0] WI_FRCH  = 5'd20;
  localparam logic [WIDX_W-1:0] WI_FRCL  = 5'd21;
  localparam logic [WIDX_W-1:0] WI_NPH   = 5'd22;
  localparam logic [WIDX_W-1:0] WI_NPL   = 5'd23;
  localparam logic [WIDX_W-1:0] WI_FPH   = 5'd24;
  localparam logic [WIDX_W-1:0] WI_FPL   = 5'd25;

  typedef struct packed {
    logic              valid;
    logic [PRIO_W-1:0] prio;
    logic [IDX_W-1:0]  idx;
  } cand_t;

  // Priority word k lives at the reversed position inside the priority window.
  function automatic logic [WIDX_W-1:0] prio_widx(input int k);
    return WIDX_W'(WI_PRIO_BASE + (PRIO_REGS - 1 - k));
  endfunction

  // Priority strictly above the level: a level of 15 or more blocks all.
  function automatic logic above_level(input logic [PRIO_W-1:0] p,
                                       input logic [MASK_W-1:0] lvl);
    return MASK_W'(p) > lvl;
  endfunction

  // Merge two candidates; hi always covers larger source numbers, so
  // it also takes equal priorities.
  function automatic cand_t cand_pick(input cand_t lo, input cand_t hi);
    if (hi.valid && (!lo.valid || hi.prio >= lo.prio)) return hi;
    return lo;
  endfunction

  function automatic logic [ID_W-1:0] vec_code(input logic found,
                                               input logic [IDX_W-1:0] id);
    return found ? ID_W'(id) : NO_SRC_ID;
  endfunction

endpackage

// File: rtl/vic_regs.sv
`timescale 1ns/1ps
module vic_regs
  import vic_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [WIDX_W-1:0]          widx_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          ctrl_o,
  output logic [MASK_W-1:0]          level_o,
  output logic [NUM_SRC-1:0]         en_o,
  output logic [NUM_SRC-1:0]         typ_o,
  output logic [NUM_SRC-1:0]         frc_o,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o
);

  logic [DATA_W-1:0]  ctrl_q;
  logic [MASK_W-1:0]  level_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] typ_q;
  logic [NUM_SRC-1:0] frc_q;

  // Events brought out for the checks below.
  logic             num_ok;
  logic [IDX_W-1:0] num_idx;
  logic             wr_enum;
  logic             wr_dnum;

  assign num_ok  = wdata_i < DATA_W'(NUM_SRC);
  assign num_idx = wdata_i[IDX_W-1:0];
  assign wr_enum = we_i && (widx_i == WI_ENUM);
  assign wr_dnum = we_i && (widx_i == WI_DNUM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      level_q <= '1;
      en_q    <= '0;
      typ_q   <= '0;
      frc_q   <= '0;
    end else if (we_i) begin
      case (widx_i)
        WI_CTRL:  ctrl_q  <= wdata_i;
        WI_LEVEL: level_q <= wdata_i[MASK_W-1:0];
        WI_ENUM:  if (num_ok) en_q[num_idx] <= 1'b1;
        WI_DNUM:  if (num_ok) en_q[num_idx] <= 1'b0;
        WI_ENH:   en_q[HALF_W +: HALF_W]  <= wdata_i;
        WI_ENL:   en_q[0 +: HALF_W]       <= wdata_i;
        WI_TYPH:  typ_q[HALF_W +: HALF_W] <= wdata_i;
        WI_TYPL:  typ_q[0 +: HALF_W]      <= wdata_i;
        WI_FRCH:  frc_q[HALF_W +: HALF_W] <= wdata_i;
        WI_FRCL:  frc_q[0 +: HALF_W]      <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < PRIO_REGS; k++) begin : g_prio
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = we_i && (widx_i == prio_widx(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '0;
      else if (hit) word_q <= wdata_i;
    end
    assign prio_o[k*DATA_W +: DATA_W] = word_q;
  end

  assign ctrl_o  = ctrl_q;
  assign level_o = level_q;
  assign en_o    = en_q;
  assign typ_o   = typ_q;
  assign frc_o   = frc_q;

  assert_bynum_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_enum && num_ok) |=> en_q[$past(num_idx)]);

  assert_bynum_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dnum && num_ok) |=> !en_q[$past(num_idx)]);

  assert_bynum_ignore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_enum || wr_dnum) && !num_ok) |=> $stable(en_q));

  assert_level_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx_i == WI_LEVEL) |=> (level_q == $past(wdata_i[MASK_W-1:0])));

endmodule

// File: rtl/vic_norm_arb.sv
`timescale 1ns/1ps
module vic_norm_arb
  import vic_pkg::*;
(
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [MASK_W-1:0]         level_i,
  output logic [NUM_SRC-1:0]        qual_o,
  output logic                      found_o,
  output logic [IDX_W-1:0]          id_o
);

  localparam int NODES = 2 * NUM_SRC - 1;
  localparam int LEAF0 = NUM_SRC - 1;

  cand_t tree [NODES];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
    assign qual_o[s] = pend_i[s] && above_level(prio_i[s*PRIO_W +: PRIO_W], level_i);
  end

  // Heap-ordered reduction: node i has children 2i+1 (lower sources)
  // and 2i+2 (higher sources).
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      tree[LEAF0+s].valid = qual_o[s];
      tree[LEAF0+s].prio  = prio_i[s*PRIO_W +: PRIO_W];
      tree[LEAF0+s].idx   = IDX_W'(s);
    end
    for (int i = LEAF0 - 1; i >= 0; i--) begin
      tree[i] = cand_pick(tree[2*i+1], tree[2*i+2]);
    end
  end

  assign found_o = tree[0].valid;
  assign id_o    = tree[0].idx;

endmodule

// File: rtl/vic_fast_enc.sv
`timescale 1ns/1ps
module vic_fast_enc
  import vic_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   id_o
);

  always_comb begin
    id_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) id_o = IDX_W'(i);
    end
  end

  assign found_o = |pend_i;

endmodule

// File: rtl/vic_core.sv
`timescale 1ns/1ps
module vic_core
  import vic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [4:0]          bus_widx_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [63:0]         src_i,
  output logic                irq_norm_o,
  output logic                irq_fast_o
);

  logic [DATA_W-1:0]         ctrl;
  logic [MASK_W-1:0]         level;
  logic [NUM_SRC-1:0]        en;
  logic [NUM_SRC-1:0]        typ;
  logic [NUM_SRC-1:0]        frc;
  logic [NUM_SRC*PRIO_W-1:0] prio;

  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] pend_norm;
  logic [NUM_SRC-1:0] pend_fast;
  logic [NUM_SRC-1:0] norm_qual;
  logic               norm_found;
  logic [IDX_W-1:0]   norm_id;
  logic               fast_found;
  logic [IDX_W-1:0]   fast_id;
  logic [ID_W-1:0]    nvec_id;
  logic [ID_W-1:0]    fvec_id;
  logic               irq_norm_q;
  logic               irq_fast_q;

  vic_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .widx_i  (bus_widx_i),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl),
    .level_o (level),
    .en_o    (en),
    .typ_o   (typ),
    .frc_o   (frc),
    .prio_o  (prio)
  );

  assign active    = (src_i | frc) & en;
  assign pend_norm = active & ~typ;
  assign pend_fast = active & typ;

  vic_norm_arb u_norm (
    .pend_i  (pend_norm),
    .prio_i  (prio),
    .level_i (level),
    .qual_o  (norm_qual),
    .found_o (norm_found),
    .id_o    (norm_id)
  );

  vic_fast_enc u_fast (
    .pend_i  (pend_fast),
    .found_o (fast_found),
    .id_o    (fast_id)
  );

  assign nvec_id = vec_code(norm_found, norm_id);
  assign fvec_id = vec_code(fast_found, fast_id);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_norm_q <= 1'b0;
      irq_fast_q <= 1'b0;
    end else begin
      irq_norm_q <= |norm_qual;
      irq_fast_q <= |pend_fast;
    end
  end

  assign irq_norm_o = irq_norm_q;
  assign irq_fast_o = irq_fast_q;

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < PRIO_REGS; k++) begin
      if (bus_widx_i == prio_widx(k)) bus_rdata_o = prio[k*DATA_W +: DATA_W];
    end
    case (bus_widx_i)
      WI_CTRL:  bus_rdata_o = ctrl;
      WI_LEVEL: bus_rdata_o = DATA_W'(level);
      WI_ENH:   bus_rdata_o = en[HALF_W +: HALF_W];
      WI_ENL:   bus_rdata_o = en[0 +: HALF_W];
      WI_TYPH:  bus_rdata_o = typ[HALF_W +: HALF_W];
      WI_TYPL:  bus_rdata_o = typ[0 +: HALF_W];
      WI_NVEC:  bus_rdata_o = {nvec_id, {(DATA_W-ID_W){1'b0}}};
      WI_FVEC:  bus_rdata_o = {fvec_id, {(DATA_W-ID_W){1'b0}}};
      WI_RAWH:  bus_rdata_o = src_i[HALF_W +: HALF_W];
      WI_RAWL:  bus_rdata_o = src_i[0 +: HALF_W];
      WI_FRCH:  bus_rdata_o = frc[HALF_W +: HALF_W];
      WI_FRCL:  bus_rdata_o = frc[0 +: HALF_W];
      WI_NPH:   bus_rdata_o = pend_norm[HALF_W +: HALF_W];
      WI_NPL:   bus_rdata_o = pend_norm[0 +: HALF_W];
      WI_FPH:   bus_rdata_o = pend_fast[HALF_W +: HALF_W];
      WI_FPL:   bus_rdata_o = pend_fast[0 +: HALF_W];
      default: ;
    endcase
  end

  assert_level_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level >= MASK_W'((1 << PRIO_W) - 1)) |=> !irq_norm_o);

  assert_norm_none_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !norm_found |=> !irq_norm_o);

  assert_norm_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_found |=> irq_norm_o);

  assert_norm_winner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_found |-> (pend_norm[norm_id] && !typ[norm_id]));

  assert_fast_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_found |=> irq_fast_o);

  assert_fast_none_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fast_found |=> !irq_fast_o);

  assert_fast_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_found |-> ((pend_fast & ((NUM_SRC'(1) << fast_id) - NUM_SRC'(1))) == '0));

  assert_fast_routed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_found |-> typ[fast_id]);

endmodule

// File: tb/vic_core_tb_top.sv
`timescale 1ns/1ps
module vic_core_tb_top;

  localparam int A_CTRL = 0, A_LVL = 1, A_ENUM = 2, A_DNUM = 3;
  localparam int A_ENH = 4, A_ENL = 5, A_TYPH = 6, A_TYPL = 7;
  localparam int A_PRIO7 = 8, A_PRIO0 = 15, A_NVEC = 16, A_FVEC = 17;
  localparam int A_RAWH = 18, A_RAWL = 19, A_FRCH = 20, A_FRCL = 21;
  localparam int A_NPH = 22, A_NPL = 23, A_FPH = 24, A_FPL = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  widx = '0;
  logic [31:0] wdata = '0;
  logic [63:0] src = '0;
  logic [31:0] rdata;
  logic        irq_n;
  logic        irq_f;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  bit [63:0]   m_en, m_typ, m_frc;
  int          m_prio [64];
  int          m_lvl;
  bit [31:0]   m_ctrl;
  bit          exp_n, exp_f;

  always #5 clk = ~clk;

  vic_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_widx_i  (widx),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .src_i       (src),
    .irq_norm_o  (irq_n),
    .irq_fast_o  (irq_f)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic int m_nsel();
    int best = -1;
    int bp = -1;
    for (int s = 0; s < 64; s++) begin
      if ((src[s] || m_frc[s]) && m_en[s] && !m_typ[s] && m_prio[s] > m_lvl && m_prio[s] >= bp) begin
        best = s;
        bp = m_prio[s];
      end
    end
    return best;
  endfunction

  function automatic int m_fsel();
    for (int s = 0; s < 64; s++)
      if ((src[s] || m_frc[s]) && m_en[s] && m_typ[s]) return s;
    return -1;
  endfunction

  function automatic logic [31:0] vword(input int sel);
    if (sel < 0) return 32'hFFFF_0000;
    return sel << 16;
  endfunction

  function automatic logic [31:0] m_read(input int w);
    bit [63:0] np, fp;
    logic [31:0] r;
    np = (src | m_frc) & m_en & ~m_typ;
    fp = (src | m_frc) & m_en & m_typ;
    r = 32'h0;
    case (w)
      A_CTRL: r = m_ctrl;
      A_LVL:  r = 32'(m_lvl);
      A_ENH:  r = m_en[63:32];
      A_ENL:  r = m_en[31:0];
      A_TYPH: r = m_typ[63:32];
      A_TYPL: r = m_typ[31:0];
      A_NVEC: r = vword(m_nsel());
      A_FVEC: r = vword(m_fsel());
      A_RAWH: r = src[63:32];
      A_RAWL: r = src[31:0];
      A_FRCH: r = m_frc[63:32];
      A_FRCL: r = m_frc[31:0];
      A_NPH:  r = np[63:32];
      A_NPL:  r = np[31:0];
      A_FPH:  r = fp[63:32];
      A_FPL:  r = fp[31:0];
      default: begin
        if (w >= A_PRIO7 && w <= A_PRIO0)
          for (int j = 0; j < 8; j++) r[4*j +: 4] = 4'(m_prio[8*(A_PRIO0 - w) + j]);
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input int w);
    if (w == A_CTRL || w == A_ENH || w == A_ENL) return "R2";
    if (w == A_LVL) return "R9";
    if (w == A_TYPH || w == A_TYPL) return "R4";
    if (w >= A_PRIO7 && w <= A_PRIO0) return "R7";
    if (w == A_NVEC) return "R8";
    if (w == A_FVEC) return "R10";
    if (w >= A_RAWH && w <= A_FRCL) return "R5";
    if (w >= A_NPH && w <= A_FPL) return "R6";
    return "R12";
  endfunction

  task automatic m_write(input int w, input logic [31:0] d);
    case (w)
      A_CTRL: m_ctrl = d;
      A_LVL:  m_lvl = int'(d[4:0]);
      A_ENUM: if (d < 64) m_en[d[5:0]] = 1'b1;
      A_DNUM: if (d < 64) m_en[d[5:0]] = 1'b0;
      A_ENH:  m_en[63:32] = d;
      A_ENL:  m_en[31:0] = d;
      A_TYPH: m_typ[63:32] = d;
      A_TYPL: m_typ[31:0] = d;
      A_FRCH: m_frc[63:32] = d;
      A_FRCL: m_frc[31:0] = d;
      default: begin
        if (w >= A_PRIO7 && w <= A_PRIO0)
          for (int j = 0; j < 8; j++) m_prio[8*(A_PRIO0 - w) + j] = int'(d[4*j +: 4]);
      end
    endcase
  endtask

  // Reference model: the request follows the state before the edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_typ = '0; m_frc = '0; m_ctrl = '0; m_lvl = 31;
      for (int s = 0; s < 64; s++) m_prio[s] = 0;
      exp_n = 1'b0; exp_f = 1'b0;
    end else begin
      exp_n = (m_nsel() >= 0);
      exp_f = (m_fsel() >= 0);
      if (we) m_write(int'(widx), wdata);
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R11 normal request", {31'b0, irq_n}, {31'b0, exp_n});
      chk("R11 fast request", {31'b0, irq_f}, {31'b0, exp_f});
      chk(tag_of(int'(widx)), rdata, m_read(int'(widx)));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); #2;
    we = 1'b1; widx = 5'(a); wdata = d;
    @(negedge clk); #2;
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); #2;
    we = 1'b0; widx = 5'(a);
    @(negedge clk); #1;
    d = rdata;
  endtask

  task automatic rdchk(input string tag, input int a, input logic [31:0] expv);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, expv);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired before the sequence ended");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    live = 1'b1;

    // R1: reset state
    rdchk("R1 level", A_LVL, 32'h1F);
    rdchk("R1 normal vector", A_NVEC, 32'hFFFF_0000);
    rdchk("R1 fast vector", A_FVEC, 32'hFFFF_0000);
    rdchk("R1 enable low", A_ENL, 32'h0);
    rdchk("R1 routing high", A_TYPH, 32'h0);
    rdchk("R1 control", A_CTRL, 32'h0);
    rdchk("R1 priority", A_PRIO0, 32'h0);
    chk("R1 requests", {30'b0, irq_n, irq_f}, 32'h0);

    // R2: word registers
    wr(A_CTRL, 32'hA5A5_0001);
    wr(A_ENL, 32'h0000_00F0);
    wr(A_ENH, 32'h8000_0001);
    rdchk("R2 control", A_CTRL, 32'hA5A5_0001);
    rdchk("R2 enable low", A_ENL, 32'h0000_00F0);
    rdchk("R2 enable high", A_ENH, 32'h8000_0001);

    // R3: enable/disable by number, out-of-range values ignored
    wr(A_ENUM, 5);
    wr(A_ENUM, 40);
    wr(A_ENUM, 64);
    wr(A_ENUM, 32'h61);
    wr(A_DNUM, 4);
    wr(A_DNUM, 32'h48);
    rdchk("R3 enable low", A_ENL, 32'h0000_00E0);
    rdchk("R3 enable high", A_ENH, 32'h8000_0101);

    // R12: reads of write-only and unmapped words
    rdchk("R12 by-number read", A_ENUM, 32'h0);
    rdchk("R12 unmapped 26", 26, 32'h0);
    rdchk("R12 unmapped 31", 31, 32'h0);

    // R8: ranking and tie-break
    wr(A_LVL, 0);
    @(negedge clk); #2 src = 64'h0000_0000_0000_00E0;
    wr(A_PRIO0, 32'h3330_0000);
    rdchk("R8 tie to higher number", A_NVEC, 32'h0007_0000);
    wr(A_PRIO0, 32'h1530_0000);
    rdchk("R8 highest priority", A_NVEC, 32'h0006_0000);

    // R7: reversed priority word placement
    wr(A_PRIO7, 32'hF000_0000);
    @(negedge clk); #2 src[63] = 1'b1;
    rdchk("R7 source 63 from word at 0x20", A_NVEC, 32'h003F_0000);
    rdchk("R7 word 7 readback", A_PRIO7, 32'hF000_0000);
    rdchk("R7 word 0 readback", A_PRIO0, 32'h1530_0000);

    // R9: level threshold
    wr(A_LVL, 5);
    rdchk("R9 level 5", A_NVEC, 32'h003F_0000);
    wr(A_LVL, 14);
    rdchk("R9 level 14", A_NVEC, 32'h003F_0000);
    wr(A_LVL, 15);
    rdchk("R9 level 15 blocks", A_NVEC, 32'hFFFF_0000);
    chk("R9 request low", {31'b0, irq_n}, 32'h0);
    wr(A_LVL, 32'h3F);
    rdchk("R9 five-bit level", A_LVL, 32'h1F);

    // R4, R6, R10: routing and pending views
    wr(A_LVL, 0);
    wr(A_TYPL, 32'h80);
    rdchk("R6 normal pending low", A_NPL, 32'h60);
    rdchk("R6 fast pending low", A_FPL, 32'h80);
    rdchk("R10 fast vector", A_FVEC, 32'h0007_0000);
    rdchk("R4 normal keeps 63", A_NVEC, 32'h003F_0000);
    @(negedge clk); #2 src[40] = 1'b1;
    wr(A_TYPH, 32'h100);
    rdchk("R6 fast pending high", A_FPH, 32'h100);
    rdchk("R10 lowest fast wins", A_FVEC, 32'h0007_0000);
    wr(A_TYPL, 0);
    rdchk("R10 fast moves to 40", A_FVEC, 32'h0028_0000);
    chk("R4 fast request", {31'b0, irq_f}, 32'h1);

    // R5: force and raw words
    @(negedge clk); #2 src = '0;
    rdchk("R5 raw low zero", A_RAWL, 32'h0);
    wr(A_FRCL, 32'h40);
    rdchk("R5 force readback", A_FRCL, 32'h40);
    rdchk("R5 forced pending", A_NPL, 32'h40);
    wr(A_RAWL, 32'hFFFF_FFFF);
    rdchk("R5 raw write ignored", A_RAWL, 32'h0);
    @(negedge clk); #2 src = 64'h1234_5678_9ABC_DEF0;
    rdchk("R5 raw high", A_RAWH, 32'h1234_5678);
    rdchk("R5 raw low", A_RAWL, 32'h9ABC_DEF0);

    // R11: one-edge latency of both requests
    @(negedge clk); #2 src = '0;
    wr(A_FRCL, 0); wr(A_FRCH, 0); wr(A_TYPH, 0);
    wr(A_ENL, 32'h1); wr(A_ENH, 0); wr(A_PRIO0, 32'h2);
    repeat (2) @(negedge clk);
    chk("R11 idle normal", {31'b0, irq_n}, 32'h0);
    wr(A_FRCL, 32'h1);
    chk("R11 normal not yet", {31'b0, irq_n}, 32'h0);
    @(posedge clk); #1;
    chk("R11 normal one edge later", {31'b0, irq_n}, 32'h1);
    wr(A_TYPL, 32'h1);
    chk("R11 fast not yet", {31'b0, irq_f}, 32'h0);
    @(posedge clk); #1;
    chk("R11 fast one edge later", {31'b0, irq_f}, 32'h1);
    chk("R11 normal dropped", {31'b0, irq_n}, 32'h0);

    // Input changes and register writes in the same cycle
    for (int it = 0; it < 600; it++) begin
      int a;
      logic [31:0] d;
      @(negedge clk); #2;
      a = int'($urandom % 26);
      d = $urandom;
      if (a == A_ENUM || a == A_DNUM) d = $urandom % 80;
      if (a == A_LVL && ($urandom % 2) == 0) d = $urandom % 8;
      src = {$urandom, $urandom} & {$urandom, $urandom};
      we = ($urandom % 3) != 0;
      widx = 5'(a);
      wdata = d;
    end
    @(negedge clk); #2 we = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule